// File: doc/BRIEF.md
# Multi-Function Timer with Overflow and Periodic Interrupt

This block is a free-running timer. A prescaler divides the system clock into ticks. An 8-bit counter advances on each tick, and its wrap from all-ones to zero sets an overflow flag. Each wrap also advances a short divider chain. Any one of four successive divider bits can be chosen as the source of a periodic interrupt flag. The two flags share one interrupt request line. Each flag is gated by its own enable bit.

Software uses a small register bus with an address, write strobe, read strobe and data. There is one control/status register and one read-only view of the counter. The flags cannot be written. Software clears each flag by writing a one to that flag's acknowledge bit, and the acknowledge bits always read as zero. After reset the rate select chooses the slowest tap. Changing the tap at the wrong moment can drop one periodic event or add an extra one, so software should discard the first event after a rate change.

Top module: `mft_timer`

## Requirements
- R1: After reset the control register (address 0) reads 0x03: both flags clear, both enables clear, rate select = 3. `timer_irq` is low.
- R2: Address 1 reads the counter, zero-extended to 8 bits. The counter advances by one every PRESCALE clock cycles. It reads 0 in the cycle after the overflow flag rises.
- R3: The overflow flag (bit 7) sets when the counter wraps from 255 to 0. Consecutive sets are therefore 256*PRESCALE cycles apart.
- R4: The periodic flag (bit 6) sets on each rising edge of divider bit TAP_BASE+sel, where sel is the rate select in bits [1:0]. The divider advances once per counter wrap, so once a rate is settled the events are 2^(sel+1)*256*PRESCALE cycles apart.
- R5: Writing ones to bit 7 or bit 6 of the control register leaves both flags unchanged.
- R6: Writing 1 to bit 3 clears the overflow flag, and writing 1 to bit 2 clears the periodic flag. Writing 0 to either of these bits leaves the flag as it was.
- R7: Bits 3 and 2 of the control register always read as 0.
- R8: `timer_irq` = (bit7 AND bit5) OR (bit6 AND bit4). Bit 5 is the overflow enable and bit 4 is the periodic enable.
- R9: A flag set event that lands in the same cycle as an acknowledge write for that flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | Register select: 0 control/status, 1 counter |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_rdata | output | 8 | Read data, zero when no read is in progress |
| timer_irq | output | 1 | Combined timer interrupt request |

## Verification
The overflow and periodic flags can each be set by the timer and cleared by a software acknowledge in the same clock edge. The bench first records the exact cycle of one flag set. From the known fixed period it computes the next set edge. It then places the acknowledge write so that it is sampled on exactly that edge. In the cycle after that edge the flag must still read as one. The bench does this once for the overflow flag and once for the periodic flag at rate 0, after discarding the possibly spurious event that follows the tap change.

// File: rtl/mft_pkg.sv
package mft_pkg;
   localparam int unsigned REG_W       = 8;
   localparam int unsigned B_OVF_FLAG  = 7;
   localparam int unsigned B_PER_FLAG  = 6;
   localparam int unsigned B_OVF_EN    = 5;
   localparam int unsigned B_PER_EN    = 4;
   localparam int unsigned B_OVF_ACK   = 3;
   localparam int unsigned B_PER_ACK   = 2;
   localparam int unsigned NUM_TAPS    = 4;
   localparam logic        ADDR_CTL    = 1'b0;
   localparam logic        ADDR_CNT    = 1'b1;

   typedef struct packed {
      logic       ovf_en;
      logic       per_en;
      logic [1:0] rate;
   } mft_ctl_t;

   localparam mft_ctl_t CTL_RESET = '{ovf_en: 1'b0, per_en: 1'b0, rate: 2'b11};
endpackage

// File: rtl/mft_count_chain.sv
module mft_count_chain #(
   parameter int unsigned PRESCALE = 2,
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned DIV_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] count,
   output logic             wrap_evt,
   output logic [DIV_W-1:0] div
);
   logic tick;

   generate
      if (PRESCALE == 1) begin : g_no_pre
         assign tick = 1'b1;
      end else begin : g_pre
         localparam int unsigned PRE_W = $clog2(PRESCALE);
         localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
         logic [PRE_W-1:0] pre_q;
         always_ff @(posedge clk) begin
            if (!rst_n)            pre_q <= '0;
            else if (pre_q == PRE_LAST) pre_q <= '0;
            else                   pre_q <= pre_q + 1'b1;
         end
         assign tick = (pre_q == PRE_LAST);
      end
   endgenerate

   assign wrap_evt = tick && (count == {CNT_W{1'b1}});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         div   <= '0;
      end else begin
         if (tick)     count <= count + 1'b1;
         if (wrap_evt) div   <= div + 1'b1;
      end
   end
endmodule

// File: rtl/mft_tap_edge.sv
module mft_tap_edge #(
   parameter int unsigned DIV_W    = 4,
   parameter int unsigned TAP_BASE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   input  logic [1:0]       sel,
   output logic             edge_evt
);
   logic [mft_pkg::NUM_TAPS-1:0] taps;
   logic tap_now;
   logic tap_q;

   for (genvar i = 0; i < int'(mft_pkg::NUM_TAPS); i++) begin : g_tap
      assign taps[i] = div[TAP_BASE + i];
   end

   assign tap_now  = taps[sel];
   assign edge_evt = tap_now && !tap_q;

   always_ff @(posedge clk) begin
      if (!rst_n) tap_q <= 1'b0;
      else        tap_q <= tap_now;
   end
endmodule

// File: rtl/mft_flag_bit.sv
module mft_flag_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic ack,
   output logic flag
);
   // a set in the same cycle as an acknowledge takes precedence
   always_ff @(posedge clk) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= set_evt || (flag && !ack);
   end
endmodule

// File: rtl/mft_timer.sv
module mft_timer #(
   parameter int unsigned PRESCALE = 2,
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned DIV_W    = 4,
   parameter int unsigned TAP_BASE = 0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_addr,
   input  logic                      bus_wr,
   input  logic [mft_pkg::REG_W-1:0] bus_wdata,
   input  logic                      bus_rd,
   output logic [mft_pkg::REG_W-1:0] bus_rdata,
   output logic                      timer_irq
);
   import mft_pkg::*;

   generate
      if (PRESCALE < 1) begin : g_bad_pre
         $error("PRESCALE must be at least 1");
      end
      if (CNT_W < 2 || CNT_W > REG_W) begin : g_bad_cnt
         $error("CNT_W must lie between 2 and the register width");
      end
      if (DIV_W < TAP_BASE + NUM_TAPS) begin : g_bad_div
         $error("DIV_W too small for the selected taps");
      end
   endgenerate

   logic [CNT_W-1:0] count;
   logic [DIV_W-1:0] div;
   logic             wrap_evt;
   logic             rt_evt;
   logic             ovf_flag;
   logic             rt_flag;
   logic             ctl_wr;
   logic             ovf_ack;
   logic             rt_ack;
   mft_ctl_t         ctl_q;
   logic [REG_W-1:0] ctl_view;
   logic [REG_W-1:0] cnt_view;

   mft_count_chain #(.PRESCALE(PRESCALE), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_chain (
      .clk(clk), .rst_n(rst_n), .count(count), .wrap_evt(wrap_evt), .div(div)
   );

   mft_tap_edge #(.DIV_W(DIV_W), .TAP_BASE(TAP_BASE)) u_tap (
      .clk(clk), .rst_n(rst_n), .div(div), .sel(ctl_q.rate), .edge_evt(rt_evt)
   );

   assign ctl_wr  = bus_wr && (bus_addr == ADDR_CTL);
   assign ovf_ack = ctl_wr && bus_wdata[B_OVF_ACK];
   assign rt_ack  = ctl_wr && bus_wdata[B_PER_ACK];

   mft_flag_bit u_ovf (
      .clk(clk), .rst_n(rst_n), .set_evt(wrap_evt), .ack(ovf_ack), .flag(ovf_flag)
   );
   mft_flag_bit u_per (
      .clk(clk), .rst_n(rst_n), .set_evt(rt_evt), .ack(rt_ack), .flag(rt_flag)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) ctl_q <= CTL_RESET;
      else if (ctl_wr) begin
         ctl_q.ovf_en <= bus_wdata[B_OVF_EN];
         ctl_q.per_en <= bus_wdata[B_PER_EN];
         ctl_q.rate   <= bus_wdata[1:0];
      end
   end

   always_comb begin
      ctl_view             = '0;
      ctl_view[B_OVF_FLAG] = ovf_flag;
      ctl_view[B_PER_FLAG] = rt_flag;
      ctl_view[B_OVF_EN]   = ctl_q.ovf_en;
      ctl_view[B_PER_EN]   = ctl_q.per_en;
      ctl_view[1:0]        = ctl_q.rate;
   end

   assign cnt_view  = REG_W'(count);
   assign bus_rdata = !bus_rd ? '0 : ((bus_addr == ADDR_CNT) ? cnt_view : ctl_view);
   assign timer_irq = (ovf_flag && ctl_q.ovf_en) || (rt_flag && ctl_q.per_en);
endmodule

// File: rtl/mft_timer_chk.sv
module mft_timer_chk #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_addr,
   input logic             bus_wr,
   input logic [7:0]       bus_wdata,
   input logic             bus_rd,
   input logic [7:0]       bus_rdata,
   input logic             timer_irq,
   input logic             ovf_flag,
   input logic             rt_flag,
   input logic             wrap_evt,
   input logic             rt_evt,
   input logic [CNT_W-1:0] count
);
   AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_addr) |-> (bus_rdata[3:2] == 2'b00)); // R7

   AST_IRQ_VS_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_addr) |-> (timer_irq == ((bus_rdata[7] && bus_rdata[5]) || (bus_rdata[6] && bus_rdata[4])))); // R8

   AST_OVF_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> $past(wrap_evt)); // R3

   AST_PER_ONLY_ON_TAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rt_flag) |-> $past(rt_evt)); // R4

   AST_WRAP_LANDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_evt |=> (count == '0)); // R2

   AST_ACK_CLEARS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_addr && bus_wdata[3] && !wrap_evt) |=> !ovf_flag); // R6

   AST_ZERO_ACK_KEEPS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_addr && !bus_wdata[3] && ovf_flag) |=> ovf_flag); // R6

   AST_OVF_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_evt |=> ovf_flag); // R9

   AST_PER_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      rt_evt |=> rt_flag); // R9
endmodule

bind mft_timer mft_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
   .timer_irq(timer_irq), .ovf_flag(ovf_flag), .rt_flag(rt_flag),
   .wrap_evt(wrap_evt), .rt_evt(rt_evt), .count(count)
);

// File: tb/mft_timer_test.sv
`timescale 1ns/1ps
module mft_timer_test;
   localparam int PRE   = 2;
   localparam int OVF_P = 256 * PRE;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       addr = 1'b0;
   logic       wr = 1'b0;
   logic [7:0] wdata = '0;
   logic       rd = 1'b0;
   logic [7:0] rdata;
   logic       irq;
   int         cyc = 0;
   int         checks = 0;
   int         fails = 0;
   logic [7:0] ctl_sh = 8'h03;
   bit         done = 1'b0;

   mft_timer #(.PRESCALE(PRE)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
      .bus_rd(rd), .bus_rdata(rdata), .timer_irq(irq)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic rd_reg(input logic a, output logic [7:0] d);
      addr = a; rd = 1'b1;
      #1 d = rdata;
      rd = 1'b0;
   endtask

   task automatic bus_write(input logic a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic wait_bit(input int b, input string req, output int at);
      logic [7:0] d;
      at = -1;
      for (int n = 0; n < 20000; n++) begin
         @(negedge clk);
         rd_reg(1'b0, d);
         if (d[b]) begin at = cyc; break; end
      end
      if (at < 0) check(1'b0, req, 0, 1);
   endtask

   task automatic drive_at(input int target, input logic [7:0] d);
      while (cyc < target - 1) @(negedge clk);
      addr = 1'b0; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic t_reset;
      logic [7:0] d;
      @(negedge clk);
      rd_reg(1'b0, d);
      check(d == 8'h03, "R1 control after reset", d, 8'h03);
      check(irq == 1'b0, "R1 irq after reset", irq, 0);
   endtask

   task automatic t_write_ignored;
      logic [7:0] d;
      bus_write(1'b0, 8'hC3);
      rd_reg(1'b0, d);
      check(d[7:6] == 2'b00, "R5 flag bits not writable", d[7:6], 0);
      bus_write(1'b0, 8'h0F);
      rd_reg(1'b0, d);
      check(d[3:2] == 2'b00, "R7 ack bits read zero", d[3:2], 0);
      check(d[1:0] == 2'b11, "R7 rate kept beside ack", d[1:0], 3);
   endtask

   task automatic t_overflow;
      int t0, t1;
      logic [7:0] d;
      wait_bit(7, "R3 overflow flag never set", t0);
      rd_reg(1'b1, d);
      check(d == 8'd0, "R2 counter zero after wrap", d, 0);
      bus_write(1'b0, ctl_sh | 8'h08);
      rd_reg(1'b1, d);
      check(int'(d) == (cyc - t0) / PRE, "R2 counter advance rate", d, (cyc - t0) / PRE);
      rd_reg(1'b0, d);
      check(d[7] == 1'b0, "R6 overflow ack clears", d[7], 0);
      wait_bit(7, "R3 overflow flag never set again", t1);
      check(t1 - t0 == OVF_P, "R3 overflow period", t1 - t0, OVF_P);
      bus_write(1'b0, ctl_sh | 8'h08);
   endtask

   task automatic t_ack;
      int t;
      logic [7:0] d;
      wait_bit(7, "R6 overflow flag never set", t);
      bus_write(1'b0, ctl_sh);
      rd_reg(1'b0, d);
      check(d[7] == 1'b1, "R6 zero ack keeps overflow", d[7], 1);
      bus_write(1'b0, ctl_sh | 8'h08);
      rd_reg(1'b0, d);
      check(d[7] == 1'b0, "R6 one ack clears overflow", d[7], 0);
      ctl_sh = 8'h00;
      bus_write(1'b0, ctl_sh | 8'h04);
      wait_bit(6, "R6 periodic flag never set", t);
      bus_write(1'b0, ctl_sh);
      rd_reg(1'b0, d);
      check(d[6] == 1'b1, "R6 zero ack keeps periodic", d[6], 1);
      bus_write(1'b0, ctl_sh | 8'h04);
      rd_reg(1'b0, d);
      check(d[6] == 1'b0, "R6 one ack clears periodic", d[6], 0);
   endtask

   task automatic t_irq;
      int t;
      ctl_sh = 8'h00;
      bus_write(1'b0, ctl_sh | 8'h08);
      wait_bit(7, "R8 overflow flag never set", t);
      check(irq == 1'b0, "R8 irq masked overflow", irq, 0);
      bus_write(1'b0, ctl_sh | 8'h20);
      check(irq == 1'b1, "R8 irq overflow enabled", irq, 1);
      bus_write(1'b0, ctl_sh | 8'h08);
      check(irq == 1'b0, "R8 irq after overflow ack", irq, 0);
      bus_write(1'b0, ctl_sh | 8'h04);
      wait_bit(6, "R8 periodic flag never set", t);
      check(irq == 1'b0, "R8 irq masked periodic", irq, 0);
      bus_write(1'b0, ctl_sh | 8'h10);
      check(irq == 1'b1, "R8 irq periodic enabled", irq, 1);
      bus_write(1'b0, ctl_sh | 8'h14);
      check(irq == 1'b0, "R8 irq after periodic ack", irq, 0);
      bus_write(1'b0, ctl_sh);
   endtask

   task automatic t_rate(input int sel);
      int t0, t1, t;
      int exp_p;
      exp_p = (2 << sel) * OVF_P;
      ctl_sh = 8'(sel);
      bus_write(1'b0, ctl_sh | 8'h04);
      wait_bit(6, "R4 periodic flag after rate change", t);
      bus_write(1'b0, ctl_sh | 8'h04);
      wait_bit(6, "R4 periodic flag first settled", t0);
      bus_write(1'b0, ctl_sh | 8'h04);
      wait_bit(6, "R4 periodic flag second settled", t1);
      bus_write(1'b0, ctl_sh | 8'h04);
      check(t1 - t0 == exp_p, $sformatf("R4 period at rate %0d", sel), t1 - t0, exp_p);
   endtask

   task automatic t_collide_ovf;
      int n;
      logic [7:0] d;
      ctl_sh = 8'h00;
      bus_write(1'b0, ctl_sh | 8'h08);
      wait_bit(7, "R9 overflow flag never set", n);
      bus_write(1'b0, ctl_sh | 8'h08);
      drive_at(n + OVF_P, ctl_sh | 8'h08);
      rd_reg(1'b0, d);
      check(d[7] == 1'b1, "R9 overflow set beats ack", d[7], 1);
      bus_write(1'b0, ctl_sh | 8'h08);
   endtask

   task automatic t_collide_per;
      int n;
      logic [7:0] d;
      ctl_sh = 8'h00;
      bus_write(1'b0, ctl_sh | 8'h04);
      wait_bit(6, "R9 periodic flag after rate change", n);
      bus_write(1'b0, ctl_sh | 8'h04);
      wait_bit(6, "R9 periodic flag settled", n);
      bus_write(1'b0, ctl_sh | 8'h04);
      drive_at(n + 2 * OVF_P, ctl_sh | 8'h04);
      rd_reg(1'b0, d);
      check(d[6] == 1'b1, "R9 periodic set beats ack", d[6], 1);
   endtask

   task automatic finish_run;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_write_ignored();
      t_overflow();
      t_ack();
      t_irq();
      for (int s = 0; s < 4; s++) t_rate(s);
      t_collide_ovf();
      t_collide_per();
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 190000);
         finish_run();
      end
   end
endmodule